// File: doc/BRIEF.md
# Multidrop UART Receiver with Mute

This block is an asynchronous serial receiver for a shared multidrop line. The line is sampled on an oversampling tick that runs at sixteen times the bit rate. Each bit value is the majority of three samples taken at the bit centre. A recovered character is delivered in `rx_data` and marked by the sticky `data_rdy` flag. Two configuration inputs set the character layout: `cfg_len9` selects the short or long data field, and `cfg_par_en` chooses whether the last field bit is a parity bit. `cfg_par_odd` selects the parity sense.

On a multidrop network, a node that finds a message is addressed to another node pulses `mute_set`. While `muted` is high, the receiver discards characters. It leaves mute through one of two hardware paths, chosen by `cfg_wake_addr`:
- With `cfg_wake_addr` at 0, it wakes when the line stays idle for a whole character time.
- With `cfg_wake_addr` at 1, it wakes on a character whose data-field MSB is 1. That address character is delivered as normal data.

The character-recovery controller has five states:
- IDLE waits for a low sample.
- START checks the start bit at its centre. It goes back to IDLE on a false start and goes to DATA at the end of the bit.
- DATA shifts in the data bits, least significant bit first. After the last one it goes to PARITY or STOP.
- PARITY captures the parity bit, then goes to STOP.
- STOP returns to IDLE at the stop-bit centre and signals a finished character.

A separate timer starts at each finished character and reports an idle line. A flag stage applies mute, wake, overrun and the sticky flags.

Top module: `mpuart_rx`

## Requirements
- R1: With `cfg_len9`=0 and `cfg_par_en`=0, a frame is a start bit, 8 data bits sent LSB first, and a stop bit. The data appears in `rx_data[7:0]` with `rx_data[8]`=0, and `data_rdy` is set.
- R2: With `cfg_len9`=1 and `cfg_par_en`=0, a frame carries 9 data bits, which appear in `rx_data[8:0]`.
- R3: With `cfg_par_en`=1, the data field is 7 bits (`cfg_len9`=0) or 8 bits (`cfg_len9`=1). The data is followed by one parity bit before the stop bit, and only the data bits appear in `rx_data`, right-aligned with zeros above.
- R4: With parity enabled, the XOR of the data bits and the parity bit must equal `cfg_par_odd` (0 means even, 1 means odd). A mismatch sets `par_err` together with `data_rdy`.
- R5: A start bit whose centre majority reads high is treated as noise. The receiver returns to IDLE and delivers nothing.
- R6: A `mute_set` pulse makes `muted` high on the next cycle. While muted, a character that does not wake the receiver leaves `data_rdy` and `rx_data` unchanged.
- R7: With `cfg_wake_addr`=0, a line held high for a full character time (16 ticks times 10 bits, or 11 bits when `cfg_len9`=1) after a stop bit clears `muted`, and `idle_flag` stays 0 for that event.
- R8: When not muted, the same idle-line condition sets `idle_flag`.
- R9: With `cfg_wake_addr`=1, a muted character whose data-field MSB is 1 clears `muted` and is delivered normally. A muted character with data MSB 0 is discarded even if its parity bit is 1.
- R10: With `cfg_wake_addr`=1, an idle line does not clear `muted`.
- R11: `data_rdy`, `idle_flag`, `par_err` and `overrun` stay set until a `flag_clr` pulse clears all four.
- R12: A character that is accepted while `data_rdy` is still set raises `overrun` and does not overwrite `rx_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len9 | input | 1 | Long data field select |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | Parity sense, 1 means odd |
| cfg_wake_addr | input | 1 | Wake method: 0 idle line, 1 address mark |
| mute_set | input | 1 | Strobe that enters mute |
| flag_clr | input | 1 | Strobe that clears all sticky flags |
| rx_data | output | 9 | Last delivered character, right-aligned |
| data_rdy | output | 1 | Character available |
| idle_flag | output | 1 | Idle line seen while not muted |
| par_err | output | 1 | Parity mismatch on delivered character |
| overrun | output | 1 | Character arrived while data_rdy set |
| muted | output | 1 | Receiver is in mute mode |

## Verification
A scoreboard holds every character the bench expects to be delivered. A receiver that leaked a muted character would produce an unexpected delivery, and one that lost a character would leave a queue entry behind.

In the 7-bit parity format, a muted character is sent with data MSB 0 and parity bit 1. A design that took the parity bit as the address mark would wake on it.

The bench also checks that an idle line in idle-wake mode clears mute without raising `idle_flag`, and that it does nothing to mute in address-wake mode. A second character sent before a clear must raise `overrun` and leave the stored data intact. A short low pulse must not produce a character.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    localparam int FIELD_W = 9;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx
    import mpr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               os_tick,
    input  logic               rxd,
    input  logic               cfg_len9,
    input  logic               cfg_par_en,
    output logic               rxd_s,
    output logic               busy,
    output logic               char_done,
    output logic [FIELD_W-1:0] data,
    output logic               data_msb,
    output logic               par_bit
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] TAP_A = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] TAP_B = CW'(OSR / 2);
    localparam logic [CW-1:0] TAP_C = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] LAST  = CW'(OSR - 1);

    rx_state_t          state_q, state_d;
    logic [1:0]         sync_q;
    logic [CW-1:0]      cnt_q;
    logic [3:0]         idx_q;
    logic [FIELD_W-1:0] shift_q;
    logic [1:0]         vote_q;
    logic               pbit_q;
    logic [3:0]         ndata;
    logic               decide, bit_end, bit_v;

    assign rxd_s   = sync_q[1];
    assign ndata   = 4'd8 + {3'b000, cfg_len9} - {3'b000, cfg_par_en};
    assign decide  = os_tick && (cnt_q == TAP_C);
    assign bit_end = os_tick && (cnt_q == LAST);
    assign bit_v   = maj3(vote_q[0], vote_q[1], rxd_s);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (os_tick && !rxd_s) state_d = RX_START;
            RX_START:  if (decide && bit_v) state_d = RX_IDLE;
                       else if (bit_end) state_d = RX_DATA;
            RX_DATA:   if (bit_end && idx_q == ndata - 4'd1)
                           state_d = cfg_par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_end) state_d = RX_STOP;
            RX_STOP:   if (decide) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            vote_q  <= '0;
            pbit_q  <= 1'b0;
        end else begin
            sync_q  <= {sync_q[0], rxd};
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (os_tick && state_q != RX_IDLE)
                cnt_q <= cnt_q + 1'b1;
            if (os_tick && cnt_q == TAP_A) vote_q[0] <= rxd_s;
            if (os_tick && cnt_q == TAP_B) vote_q[1] <= rxd_s;
            if (state_q == RX_IDLE && state_d == RX_START) begin
                shift_q <= '0;
                idx_q   <= '0;
            end
            if (state_q == RX_DATA && decide)
                shift_q <= {bit_v, shift_q[FIELD_W-1:1]};
            if (state_q == RX_DATA && bit_end && idx_q != ndata - 4'd1)
                idx_q <= idx_q + 4'd1;
            if (state_q == RX_PARITY && decide)
                pbit_q <= bit_v;
        end
    end

    always_comb begin
        busy      = (state_q != RX_IDLE);
        char_done = (state_q == RX_STOP) && decide;
        data      = shift_q >> (4'd9 - ndata);
        data_msb  = data[ndata - 4'd1];
        par_bit   = pbit_q;
    end

endmodule

// File: rtl/mpr_idle_det.sv
module mpr_idle_det #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rxd_s,
    input  logic busy,
    input  logic char_done,
    input  logic cfg_len9,
    output logic idle_det
);
    localparam int LW = $clog2(11 * OSR) + 1;

    logic [LW-1:0] cnt_q, limit;
    logic          armed_q;

    assign limit = cfg_len9 ? LW'(11 * OSR) : LW'(10 * OSR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            idle_det <= 1'b0;
        end else begin
            idle_det <= 1'b0;
            if (char_done) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (busy) begin
                armed_q <= 1'b0;
            end else if (armed_q && os_tick) begin
                if (!rxd_s) begin
                    armed_q <= 1'b0;
                end else if (cnt_q == limit - 1'b1) begin
                    armed_q  <= 1'b0;
                    idle_det <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               os_tick,
    input  logic               rxd,
    input  logic               cfg_len9,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_wake_addr,
    input  logic               mute_set,
    input  logic               flag_clr,
    output logic [FIELD_W-1:0] rx_data,
    output logic               data_rdy,
    output logic               idle_flag,
    output logic               par_err,
    output logic               overrun,
    output logic               muted
);
    logic               rxd_s, busy, done, msb, pbit, idle_det;
    logic [FIELD_W-1:0] fdata;
    logic               wake_hit, accept, par_bad;

    mpr_frame_rx #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_len9(cfg_len9), .cfg_par_en(cfg_par_en),
        .rxd_s(rxd_s), .busy(busy), .char_done(done),
        .data(fdata), .data_msb(msb), .par_bit(pbit)
    );

    mpr_idle_det #(.OSR(OSR)) u_idle (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_s(rxd_s),
        .busy(busy), .char_done(done), .cfg_len9(cfg_len9),
        .idle_det(idle_det)
    );

    assign wake_hit = cfg_wake_addr && msb;
    assign accept   = !muted || wake_hit;
    assign par_bad  = cfg_par_en && ((^fdata ^ pbit) != cfg_par_odd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            data_rdy  <= 1'b0;
            idle_flag <= 1'b0;
            par_err   <= 1'b0;
            overrun   <= 1'b0;
            muted     <= 1'b0;
        end else begin
            if (flag_clr) begin
                data_rdy  <= 1'b0;
                idle_flag <= 1'b0;
                par_err   <= 1'b0;
                overrun   <= 1'b0;
            end
            if (done && accept) begin
                if (muted) muted <= 1'b0;
                if (data_rdy) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data  <= fdata;
                    data_rdy <= 1'b1;
                    par_err  <= par_bad;
                end
            end
            if (idle_det) begin
                if (!muted) idle_flag <= 1'b1;
                else if (!cfg_wake_addr) muted <= 1'b0;
            end
            if (mute_set) muted <= 1'b1;
        end
    end

    // R6
    mute_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_set |=> muted);

    // R6
    muted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && muted && !wake_hit && !flag_clr) |=> ($stable(rx_data) && $stable(data_rdy)));

    // R7
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_det && muted && !cfg_wake_addr && !flag_clr && !mute_set)
            |=> (!muted && $stable(idle_flag)));

    // R9
    addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && muted && cfg_wake_addr && msb && !mute_set && !flag_clr)
            |=> (!muted && data_rdy));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_det && muted && cfg_wake_addr && !done) |=> muted);

    // R12
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept && data_rdy && !flag_clr) |=> (overrun && $stable(rx_data)));

endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;
    localparam int IDLE_WAIT  = 440;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len9 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_wake_addr = 1'b0;
    logic       mute_set = 1'b0, flag_clr = 1'b0;
    logic [8:0] rx_data;
    logic       data_rdy, idle_flag, par_err, overrun, muted;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    typedef struct {
        logic [8:0] d;
        logic       pe;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    mpuart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_len9(cfg_len9), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_wake_addr(cfg_wake_addr), .mute_set(mute_set), .flag_clr(flag_clr),
        .rx_data(rx_data), .data_rdy(data_rdy), .idle_flag(idle_flag),
        .par_err(par_err), .overrun(overrun), .muted(muted)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    logic dr_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && data_rdy && !dr_prev) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected delivery", int'(rx_data), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rx_data == e.d, e.tag, int'(rx_data), int'(e.d));
                chk(par_err == e.pe, {e.tag, " par_err"}, int'(par_err), int'(e.pe));
            end
        end
        dr_prev = data_rdy;
    end

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_char(input logic [8:0] d, input int nd, input logic pen, input logic pval);
        hold_bit(1'b0);
        for (int i = 0; i < nd; i++) hold_bit(d[i]);
        if (pen) hold_bit(pval);
        hold_bit(1'b1);
    endtask

    task automatic expect_char(input logic [8:0] d, input logic pe, input string tag);
        exp_t e;
        e.d = d; e.pe = pe; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse_clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic pulse_mute();
        @(negedge clk) mute_set = 1'b1;
        @(negedge clk) mute_set = 1'b0;
    endtask

    task automatic settle();
        repeat (IDLE_WAIT) @(negedge clk);
        pulse_clr();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk({data_rdy, idle_flag, par_err, overrun, muted} == 5'b0, "R11 reset flags",
            int'({data_rdy, idle_flag, par_err, overrun, muted}), 0);

        // R1 short format, no parity
        expect_char(9'h0A5, 1'b0, "R1 8-bit A5");
        send_char(9'h0A5, 8, 1'b0, 1'b0);
        chk(data_rdy == 1'b1, "R1 data_rdy", int'(data_rdy), 1);
        pulse_clr();
        expect_char(9'h03C, 1'b0, "R1 8-bit 3C");
        send_char(9'h03C, 8, 1'b0, 1'b0);
        // R12 overrun keeps stored data
        send_char(9'h011, 8, 1'b0, 1'b0);
        chk(overrun == 1'b1, "R12 overrun", int'(overrun), 1);
        chk(rx_data == 9'h03C, "R12 data kept", int'(rx_data), 'h3C);
        pulse_clr();
        // R11 clear strobe
        chk({data_rdy, par_err, overrun} == 3'b0, "R11 cleared",
            int'({data_rdy, par_err, overrun}), 0);
        settle();

        // R2 long format
        cfg_len9 = 1'b1;
        expect_char(9'h1C3, 1'b0, "R2 9-bit 1C3");
        send_char(9'h1C3, 9, 1'b0, 1'b0);
        settle();

        // R3 R4 short format with even parity
        cfg_len9 = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        expect_char(9'h055, 1'b0, "R3 7-bit even ok");
        send_char(9'h055, 7, 1'b1, ^7'h55);
        pulse_clr();
        expect_char(9'h055, 1'b1, "R4 7-bit even bad");
        send_char(9'h055, 7, 1'b1, ~(^7'h55));
        chk(par_err == 1'b1, "R4 par_err set", int'(par_err), 1);
        pulse_clr();
        // R3 R4 long format with odd parity
        cfg_len9 = 1'b1; cfg_par_odd = 1'b1;
        expect_char(9'h0F1, 1'b0, "R3 8-bit odd ok");
        send_char(9'h0F1, 8, 1'b1, ~(^8'hF1));
        pulse_clr();
        expect_char(9'h0F1, 1'b1, "R4 8-bit odd bad");
        send_char(9'h0F1, 8, 1'b1, ^8'hF1);
        settle();

        // R5 false start
        cfg_len9 = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (IDLE_WAIT) @(negedge clk);
        chk(data_rdy == 1'b0, "R5 false start ignored", int'(data_rdy), 0);

        // R8 idle flag while not muted
        expect_char(9'h05A, 1'b0, "R8 pre-idle char");
        send_char(9'h05A, 8, 1'b0, 1'b0);
        repeat (IDLE_WAIT) @(negedge clk);
        chk(idle_flag == 1'b1, "R8 idle_flag", int'(idle_flag), 1);
        pulse_clr();

        // R6 R7 idle-line wake
        cfg_wake_addr = 1'b0;
        pulse_mute();
        chk(muted == 1'b1, "R6 muted", int'(muted), 1);
        send_char(9'h077, 8, 1'b0, 1'b0);
        chk(data_rdy == 1'b0, "R6 no data_rdy", int'(data_rdy), 0);
        chk(rx_data == 9'h05A, "R6 data unchanged", int'(rx_data), 'h5A);
        repeat (IDLE_WAIT) @(negedge clk);
        chk(muted == 1'b0, "R7 idle wake", int'(muted), 0);
        chk(idle_flag == 1'b0, "R7 idle flag quiet", int'(idle_flag), 0);
        expect_char(9'h021, 1'b0, "R7 after wake");
        send_char(9'h021, 8, 1'b0, 1'b0);
        settle();

        // R9 R10 address-mark wake
        cfg_wake_addr = 1'b1;
        pulse_mute();
        send_char(9'h012, 8, 1'b0, 1'b0);
        chk(rx_data == 9'h021 && !data_rdy && muted, "R9 msb0 discarded",
            int'({data_rdy, muted}), 1);
        repeat (IDLE_WAIT) @(negedge clk);
        chk(muted == 1'b1, "R10 idle no wake", int'(muted), 1);
        chk(idle_flag == 1'b0, "R10 idle flag quiet", int'(idle_flag), 0);
        expect_char(9'h093, 1'b0, "R9 address 93");
        send_char(9'h093, 8, 1'b0, 1'b0);
        chk(muted == 1'b0, "R9 address wake", int'(muted), 0);
        settle();
        // R9 parity format: parity bit is not the mark
        cfg_par_en = 1'b1;
        pulse_mute();
        send_char(9'h004, 7, 1'b1, 1'b1);
        chk(muted == 1'b1 && !data_rdy, "R9 parity bit ignored", int'({data_rdy, muted}), 1);
        expect_char(9'h041, 1'b0, "R9 7-bit address 41");
        send_char(9'h041, 7, 1'b1, ^7'h41);
        chk(muted == 1'b0, "R9 7-bit wake", int'(muted), 0);
        settle();

        // R1 scoreboard drained
        chk(exp_q.size() == 0, "R1 all expected delivered", exp_q.size(), 0);

        done_run = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule